// File: doc/BRIEF.md
# Multi-Resolution Dead-Time PWM Generator

This block produces a pulse-width modulated switching signal with a fixed period of 513 clock cycles, whatever the duty resolution. A width select chooses a 5- to 9-bit duty word. The duty is stretched onto the shared period by a left shift and a small centring offset. An external modulator can lengthen any single period by one cycle through a one-bit increment input. The block emits a one-cycle strobe at every period start so that the modulator can step once per period.

The raw level is split into a high-side and a low-side gate drive. After every level change both outputs stay low for six cycles. A square-wave sync output toggles once per period. Five debug outputs show the upper bits of the latched duty after it has been shifted into the 9-bit domain. The duty, increment and width are sampled once, on the edge that starts a period, so a period never mixes two compare values.

Top module: `multires_pwm`

## Requirements
- R1: `period_start` is high for exactly one cycle in every 513 (counter value 0). The first strobe comes in the first cycle after reset is released.
- R2: `width_sel` values 0,1,2,3,4 select B = 5,6,7,8,9 duty bits, taken from the low B bits of `duty_in`. The compare value is duty·2^(9−B) + max(1, 2^(8−B)). The raw level is high while the counter (0 to 512) is below the compare value.
- R3: Compare value, width and debug duty are loaded only on the edge that starts a period. Input changes at any other time leave the running period unchanged.
- R4: When `duty_inc` is 1 at the period-start edge, the compare value for that period is one larger.
- R5: `pwm_hi` is high only once the raw level has been high for 7 consecutive sampled cycles. `pwm_lo` is high only once it has been low for 7. This gives 6 cycles with both outputs low after every transition, and the two outputs are never high together.
- R6: `sync_clk` is 0 in reset and toggles in every cycle where `period_start` is high.
- R7: `duty_msb` equals bits [8:4] of the latched duty after a left shift by 9−B.
- R8: `width_sel` values 5 to 7 are ignored and the previously latched width is kept. Out of reset the latched width is 8 bits.
- R9: A compare value of 513 (9-bit full scale with increment) holds `pwm_hi` high across period boundaries, and `pwm_lo` never asserts.
- R10: While reset is active, `pwm_hi`, `pwm_lo`, `sync_clk`, `period_start` and `duty_msb` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_in | input | 9 | Base duty, low B bits used |
| width_sel | input | 3 | Resolution select (0 = 5-bit to 4 = 9-bit) |
| duty_inc | input | 1 | One-cycle lengthening request for the next period |
| pwm_hi | output | 1 | High-side gate drive |
| pwm_lo | output | 1 | Low-side gate drive |
| sync_clk | output | 1 | Square wave toggling each period |
| period_start | output | 1 | One-cycle strobe at counter value 0 |
| duty_msb | output | 5 | Upper bits of the normalised latched duty |

## Verification
The period-boundary latch and a change of duty, width or increment can land on the same edge. The sample taken there decides the whole next period. The bench provokes this by changing all three inputs on every cycle for many periods, so that every wrap edge sees fresh values. A cycle-level reference model judges each cycle by taking only the value present at the wrap edge. A second collision, a raw level change at the wrap edge, is driven with full-scale and near-full-scale compare values. The dead-time window must then restart or hold across the boundary exactly as R5 and R9 require.

// File: rtl/mrpwm_pkg.sv
package mrpwm_pkg;

  // left-aligns a B-bit duty into the max_bits domain
  function automatic logic [15:0] norm_duty(input logic [15:0] duty,
                                            input logic [4:0]  bits,
                                            input logic [4:0]  max_bits);
    logic [15:0] mask;
    mask = (16'd1 << bits) - 16'd1;
    return (duty & mask) << (max_bits - bits);
  endfunction

  // normalised duty plus the centring offset max(1, 2^(max_bits-1-bits))
  function automatic logic [15:0] scale_duty(input logic [15:0] duty,
                                             input logic [4:0]  bits,
                                             input logic [4:0]  max_bits);
    logic [15:0] off;
    off = (bits + 5'd1 >= max_bits) ? 16'd1 : (16'd1 << (max_bits - 5'd1 - bits));
    return norm_duty(duty, bits, max_bits) + off;
  endfunction

endpackage

// File: rtl/mrpwm_period_timer.sv
module mrpwm_period_timer #(
  parameter int PERIOD = 513,
  parameter int CNT_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             start,
  output logic             sync
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  // reset to the last count so the first edge opens a period (R1)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= LAST;
      sync  <= 1'b0;
    end else begin
      count <= wrap ? '0 : count + 1'b1;
      sync  <= sync ^ wrap;
    end
  end

  assign wrap  = (count == LAST);
  assign start = (count == '0);
endmodule

// File: rtl/mrpwm_duty_latch.sv
module mrpwm_duty_latch
  import mrpwm_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 9,
  parameter int RST_SEL  = 3,
  parameter int SEL_W    = 3,
  parameter int CNT_W    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_BITS-1:0] duty,
  input  logic [SEL_W-1:0]    sel,
  input  logic                inc,
  output logic [CNT_W-1:0]    cmp,
  output logic [MAX_BITS-1:0] norm
);
  localparam int NUM_RES = MAX_BITS - MIN_BITS + 1;

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_eff;
  logic             sel_ok;
  logic [4:0]       bits_eff;
  logic [15:0]      scaled;
  logic [15:0]      normed;

  // out-of-range selects keep the held width (R8)
  assign sel_ok   = ({1'b0, sel} < (SEL_W + 1)'(NUM_RES));
  assign sel_eff  = sel_ok ? sel : sel_q;
  assign bits_eff = 5'(MIN_BITS) + 5'(sel_eff);
  assign scaled   = scale_duty(16'(duty), bits_eff, 5'(MAX_BITS)) + 16'(inc);
  assign normed   = norm_duty(16'(duty), bits_eff, 5'(MAX_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEL_W'(RST_SEL);
      cmp   <= '0;
      norm  <= '0;
    end else if (load) begin
      sel_q <= sel_eff;
      cmp   <= CNT_W'(scaled);
      norm  <= MAX_BITS'(normed);
    end
  end
endmodule

// File: rtl/mrpwm_deadband.sv
module mrpwm_deadband #(
  parameter int DEAD = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic hi,
  output logic lo
);
  logic lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl <= 1'b0;
    else        lvl <= raw;
  end

  generate
    if (DEAD == 0) begin : g_direct
      assign hi = lvl;
      assign lo = ~lvl;
    end else begin : g_gap
      localparam int SCW = $clog2(DEAD + 1);
      logic [SCW-1:0] run;
      logic           settled;

      // run counts edges since the level last changed, saturating
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     run <= '0;
        else if (raw != lvl)            run <= '0;
        else if (run != SCW'(DEAD))     run <= run + 1'b1;
      end

      assign settled = (run == SCW'(DEAD));
      assign hi      = lvl & settled;
      assign lo      = ~lvl & settled;
    end
  endgenerate
endmodule

// File: rtl/multires_pwm.sv
module multires_pwm
  import mrpwm_pkg::*;
#(
  parameter  int MIN_BITS = 5,
  parameter  int MAX_BITS = 9,
  parameter  int DEAD     = 6,
  parameter  int RST_SEL  = 3,
  parameter  int MSB_OUT  = 5,
  localparam int NUM_RES  = MAX_BITS - MIN_BITS + 1,
  localparam int SEL_W    = $clog2(NUM_RES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAX_BITS-1:0] duty_in,
  input  logic [SEL_W-1:0]    width_sel,
  input  logic                duty_inc,
  output logic                pwm_hi,
  output logic                pwm_lo,
  output logic                sync_clk,
  output logic                period_start,
  output logic [MSB_OUT-1:0]  duty_msb
);
  localparam int PERIOD = (1 << MAX_BITS) + 1;
  localparam int CNT_W  = $clog2(PERIOD + 1);

  logic [CNT_W-1:0]    count;
  logic                wrap;
  logic [CNT_W-1:0]    cmp_q;
  logic [MAX_BITS-1:0] norm_q;
  logic                raw_lvl;

  mrpwm_period_timer #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .count (count),
    .wrap  (wrap),
    .start (period_start),
    .sync  (sync_clk)
  );

  mrpwm_duty_latch #(
    .MIN_BITS (MIN_BITS),
    .MAX_BITS (MAX_BITS),
    .RST_SEL  (RST_SEL),
    .SEL_W    (SEL_W),
    .CNT_W    (CNT_W)
  ) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wrap),
    .duty  (duty_in),
    .sel   (width_sel),
    .inc   (duty_inc),
    .cmp   (cmp_q),
    .norm  (norm_q)
  );

  assign raw_lvl = (count < cmp_q);

  mrpwm_deadband #(.DEAD(DEAD)) u_dead (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (raw_lvl),
    .hi    (pwm_hi),
    .lo    (pwm_lo)
  );

  assign duty_msb = norm_q[MAX_BITS-1 -: MSB_OUT];
endmodule

// File: rtl/multires_pwm_checker.sv
module multires_pwm_checker #(
  parameter int DEAD = 6,
  parameter int CW   = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwm_hi,
  input logic          pwm_lo,
  input logic          sync_clk,
  input logic          period_start,
  input logic [CW-1:0] cmp_q
);
  localparam int GW = (DEAD > 0) ? $clog2(DEAD + 1) : 1;

  // consecutive cycles with both gate drives low, saturating
  logic [GW-1:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap <= '0;
    else if (pwm_hi | pwm_lo)  gap <= '0;
    else if (gap != GW'(DEAD)) gap <= gap + 1'b1;
  end

  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_hi && pwm_lo));

  p_hi_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_hi) |-> (gap >= GW'(DEAD)));

  p_lo_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_lo) |-> (gap >= GW'(DEAD)));

  p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |=> !period_start);

  p_sync_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sync_clk) |-> period_start);

  p_cmp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> $stable(cmp_q));
endmodule

bind multires_pwm multires_pwm_checker #(.DEAD(DEAD), .CW(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pwm_hi       (pwm_hi),
  .pwm_lo       (pwm_lo),
  .sync_clk     (sync_clk),
  .period_start (period_start),
  .cmp_q        (cmp_q)
);

// File: tb/multires_pwm_tb.sv
`timescale 1ns/1ps
module multires_pwm_tb;
  localparam int DEAD = 6;
  localparam int PER  = 513;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] duty;
  logic [2:0] wsel;
  logic       inc;
  logic       pwm_hi, pwm_lo, sync_clk, period_start;
  logic [4:0] duty_msb;

  always #2.5 clk = ~clk;

  multires_pwm u_dut (
    .clk(clk), .rst_n(rst_n), .duty_in(duty), .width_sel(wsel), .duty_inc(inc),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .sync_clk(sync_clk),
    .period_start(period_start), .duty_msb(duty_msb)
  );

  int n_vec = 0, n_bad = 0;
  int m_cnt, m_cmp, m_sel, m_norm, nvalid;
  bit m_sync;
  bit hist [0:DEAD];
  int cyc = 0, last_strobe = -1;
  int hi_acc = 0, lo_acc = 0, hi_last = 0, lo_last = 0;
  bit done = 0;

  function automatic int ref_scale(int d, int b);
    int off;
    off = (b >= 8) ? 1 : (1 << (8 - b));
    return (d % (1 << b)) * (1 << (9 - b)) + off;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(string ph, int d, int s, int i);
    bit e_hi, e_lo, raw;
    e_hi = (nvalid >= DEAD + 1);
    e_lo = e_hi;
    for (int k = 0; k <= DEAD; k++) begin
      if (!hist[k]) e_hi = 0;
      if (hist[k])  e_lo = 0;
    end
    chk({ph, " R2 R4 R5 pwm_hi"}, int'(pwm_hi), int'(e_hi));
    chk({ph, " R5 pwm_lo"}, int'(pwm_lo), int'(e_lo));
    chk({ph, " R5 overlap"}, int'(pwm_hi & pwm_lo), 0);
    chk({ph, " R1 period_start"}, int'(period_start), int'(m_cnt == 0));
    chk({ph, " R6 sync_clk"}, int'(sync_clk), int'(m_sync));
    chk({ph, " R7 duty_msb"}, int'(duty_msb), m_norm >> 4);
    if (period_start) begin
      if (last_strobe >= 0) chk({ph, " R1 spacing"}, cyc - last_strobe, PER);
      last_strobe = cyc;
      hi_last = hi_acc; lo_last = lo_acc; hi_acc = 0; lo_acc = 0;
    end
    hi_acc += int'(pwm_hi);
    lo_acc += int'(pwm_lo);
    duty = 9'(d); wsel = 3'(s); inc = 1'(i);
    raw = (m_cnt < m_cmp);
    for (int k = DEAD; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = raw;
    if (nvalid < DEAD + 1) nvalid++;
    if (m_cnt == PER - 1) begin
      if (s < 5) m_sel = s;
      m_cmp  = ref_scale(d, 5 + m_sel) + i;
      m_norm = (d % (1 << (5 + m_sel))) * (1 << (4 - m_sel));
      m_sync = !m_sync;
      m_cnt  = 0;
    end else begin
      m_cnt++;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic hold(string ph, int periods, int d, int s, int i);
    for (int n = 0; n < periods * PER; n++) step(ph, d, s, i);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: got %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; duty = 9'h080; wsel = 3'd7; inc = 1'b0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 reset pwm_hi", int'(pwm_hi), 0);
    chk("R10 reset pwm_lo", int'(pwm_lo), 0);
    chk("R10 reset sync", int'(sync_clk), 0);
    chk("R10 reset strobe", int'(period_start), 0);
    chk("R10 reset duty_msb", int'(duty_msb), 0);
    m_cnt = PER - 1; m_cmp = 0; m_sel = 3; m_norm = 0; m_sync = 0;
    for (int k = 0; k <= DEAD; k++) hist[k] = 0;
    nvalid = 1;
    rst_n = 1'b1;

    // R8: invalid select out of reset keeps the 8-bit default: 128*2+1 = 257
    hold("R8 default", 3, 9'h080, 7, 0);
    chk("R8 high-side width", hi_last, 257 - DEAD);

    // R2 R4: 5-bit full code plus increment: 31*16+8+1 = 505
    hold("R2 R4 5bit", 3, 31, 0, 1);
    chk("R2 R4 high-side width", hi_last, 505 - DEAD);

    // R9: 9-bit full scale plus increment -> 513, continuous high side
    hold("R9 full", 3, 511, 4, 1);
    chk("R9 high-side width", hi_last, PER);
    chk("R9 low-side count", lo_last, 0);

    // R2: 9-bit zero -> compare 1, pulse shorter than the dead-time
    hold("R2 zero", 3, 0, 4, 0);
    chk("R2 zero high-side", hi_last, 0);

    // R8: invalid select after 6-bit keeps 6-bit: 40*8+4 = 324
    hold("R8 keep6", 2, 40, 1, 0);
    hold("R8 keep6", 2, 40, 6, 0);
    chk("R8 kept width", hi_last, 324 - DEAD);

    // R3 R2 R4: random values held per period
    for (int n = 0; n < 10; n++)
      hold("R3 held-random", 1, int'($urandom % 512), int'($urandom % 8), int'($urandom % 2));

    // R3: inputs change every cycle, so every wrap edge sees new values
    for (int n = 0; n < 10 * PER; n++)
      step("R3 churn", int'($urandom % 512), int'($urandom % 8), int'($urandom % 2));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule